// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a single-clock synchronous SRAM. The word is 36 bits wide, split into four 9-bit lanes, and the full-size array holds 128K words. An access begins when either of two address strobes is asserted. The chip-select inputs are checked only in that cycle. After an access has begun, the block generates the addresses that follow within an aligned group of four words. It does this with a 2-bit burst counter that runs in either linear or interleaved order.

Writes are registered on the same edge as their address. Each write stores either the whole word or any chosen set of lanes. Read data goes through an output register, so it appears two rising edges after its address is captured.

The output-enable and sleep inputs gate the output drive combinationally. While asleep, the block takes no accesses and keeps its contents. The depth is set by a parameter: the default is kept small for elaboration, and `ADDR_W = 17` gives the full 128K-word array.

Top module: `sync_burst_sram`

## Requirements
- R1: A read whose address is captured at rising edge k drives its data on `rdata`, with `rvalid` high, after edge k+1 and not before. The output after edge k shows the previous cycle's result.
- R2: When `wr_all_n` is low in an access cycle, all four lanes are written, whatever the values of `lane_wr_en_n` and `lane_sel_n`.
- R3: When `wr_all_n` is high and `lane_wr_en_n` is low, lane i is written only if `lane_sel_n[i]` is low. Lane i is `wdata[9i+8:9i]`, so bit 0 of `lane_sel_n` controls bits 8:0 and bit 3 controls bits 35:27. Lanes that are not selected keep their old value. A write cycle leaves `rvalid` low two edges later.
- R4: When `wr_all_n` and `lane_wr_en_n` are both high, `lane_sel_n` is ignored and the cycle is a read. A cycle with `lane_wr_en_n` low but every `lane_sel_n` bit high is also a read. Neither case changes the memory.
- R5: A strobe starts an access only when `cs1_n` is 0, `cs2` is 1 and `cs3_n` is 0. A strobe with any other combination deselects the device. A deselect writes nothing, ends any burst, and gives `rvalid` low two edges later.
- R6: An assertion of `strobe_cpu_n` while `cs1_n` is high is ignored entirely, and the current burst goes on as if no strobe had been given.
- R7: With `interleave` low, the access n steps into a burst uses address bits [1:0] equal to the start address's bits [1:0] plus n, modulo 4. The upper bits stay fixed.
- R8: With `interleave` high, the access n steps into a burst uses address bits [1:0] equal to the start address's bits [1:0] XOR n.
- R9: In a cycle with no strobe and `burst_step_n` high, an active burst accesses the same address again.
- R10: While `out_en_n` is high, `rvalid` is low and `rdata` is zero. This takes effect without waiting for a clock edge.
- R11: While `sleep` is high, `rvalid` is low, strobes and writes are ignored, and the memory is kept. Sleep also ends the burst, so after waking no access happens until a new strobe.
- R12: During reset and after it, `rvalid` stays low until a strobe starts an access.
- R13: A read that begins in the cycle right after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the control state |
| addr | input | ADDR_W | Word address, captured on a strobe |
| wdata | input | 36 | Write data, four 9-bit lanes |
| strobe_cpu_n | input | 1 | Address strobe, qualified by `cs1_n` |
| strobe_ctl_n | input | 1 | Address strobe, always honoured |
| burst_step_n | input | 1 | Low: move to the next burst address |
| wr_all_n | input | 1 | Low: write the whole word |
| lane_wr_en_n | input | 1 | Low: qualify the per-lane write selects |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| cs1_n | input | 1 | Primary chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| out_en_n | input | 1 | Output enable, active low, combinational |
| interleave | input | 1 | Burst order: 1 interleaved, 0 linear |
| sleep | input | 1 | Power-down: no accesses, output off |
| rdata | output | 36 | Registered read data, zero when not driven |
| rvalid | output | 1 | Read data is being driven |

## Verification
A fault in the burst base or counter shows up as wrong data. It appears on `rdata` one edge after the bad address is used, which is two edges after the cycle that caused it. The bench catches it by reading a group of four words that hold distinct values, in both burst orders and across a suspend cycle. A wrong active or select state shows up as `rvalid` being high or low at the wrong time, two edges after the strobe. A lost or extra lane write only becomes visible at a later read-back of that word. For that reason, every write pattern in the bench is followed at once by a read of the same address.

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W = 9,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    strobe_cpu_n,
  input  logic                    strobe_ctl_n,
  input  logic                    burst_step_n,
  input  logic                    wr_all_n,
  input  logic                    lane_wr_en_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic                    cs1_n,
  input  logic                    cs2,
  input  logic                    cs3_n,
  input  logic                    out_en_n,
  input  logic                    interleave,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic              active;
  logic [ADDR_W-1:0] base;
  logic [1:0]        cnt;

  logic              s1_rd;
  logic [LANES-1:0]  s1_mask;
  logic [ADDR_W-1:0] s1_addr;
  logic [DW-1:0]     s1_wd;
  logic              valid_q;
  logic [DW-1:0]     out_bus;

  wire selected = !cs1_n && cs2 && !cs3_n;
  wire start    = !strobe_ctl_n || (!strobe_cpu_n && !cs1_n);
  wire [1:0] cnt_nx = burst_step_n ? cnt : cnt + 2'd1;
  wire [1:0] low_nx = interleave ? (base[1:0] ^ cnt_nx) : (base[1:0] + cnt_nx);
  wire [ADDR_W-1:0] acc_addr = start ? addr : {base[ADDR_W-1:2], low_nx};
  wire access = !sleep && (start ? selected : active);
  wire [LANES-1:0] lane_mask = !wr_all_n ? {LANES{1'b1}}
                             : (!lane_wr_en_n ? ~lane_sel_n : {LANES{1'b0}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= '0;
      cnt    <= '0;
    end else if (sleep) begin
      active <= 1'b0;
    end else if (start) begin
      active <= selected;
      base   <= addr;
      cnt    <= '0;
    end else if (active) begin
      cnt    <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_rd   <= 1'b0;
      s1_mask <= '0;
      valid_q <= 1'b0;
    end else begin
      s1_rd   <= access && (lane_mask == '0);
      s1_mask <= access ? lane_mask : '0;
      valid_q <= s1_rd;
    end
  end

  always_ff @(posedge clk) begin
    s1_addr <= acc_addr;
    s1_wd   <= wdata;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] out_q;
    always_ff @(posedge clk) begin
      if (s1_mask[g]) mem[s1_addr] <= s1_wd[g*LANE_W +: LANE_W];
      if (s1_rd) out_q <= mem[s1_addr];
    end
    assign out_bus[g*LANE_W +: LANE_W] = out_q;
  end

  assign rvalid = valid_q && !out_en_n && !sleep;
  assign rdata  = rvalid ? out_bus : '0;
endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    strobe_ctl_n,
  input logic                    wr_all_n,
  input logic                    lane_wr_en_n,
  input logic [LANES-1:0]        lane_sel_n,
  input logic                    cs1_n,
  input logic                    cs2,
  input logic                    cs3_n,
  input logic                    out_en_n,
  input logic                    sleep,
  input logic [LANES*LANE_W-1:0] rdata,
  input logic                    rvalid
);
  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  wire sel_ok   = !cs1_n && cs2 && !cs3_n;
  wire is_write = !wr_all_n || (!lane_wr_en_n && (lane_sel_n != '1));
  wire ctl_read = !strobe_ctl_n && sel_ok && !is_write && !sleep;
  wire ctl_desel = !strobe_ctl_n && !sel_ok;
  wire ctl_write = !strobe_ctl_n && sel_ok && is_write && !sleep;

  p_rd_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && !out_en_n && !sleep && $past(ctl_read, 2)) |-> rvalid);

  p_desel_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && $past(ctl_desel, 2)) |-> !rvalid);

  p_write_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && $past(ctl_write, 2)) |-> !rvalid);

  p_oe_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> (!rvalid && rdata == '0));

  p_sleep_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rvalid);
endmodule

bind sync_burst_sram sync_burst_sram_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe_ctl_n(strobe_ctl_n), .wr_all_n(wr_all_n),
  .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n), .cs1_n(cs1_n),
  .cs2(cs2), .cs3_n(cs3_n), .out_en_n(out_en_n), .sleep(sleep),
  .rdata(rdata), .rvalid(rvalid)
);

// File: tb/sync_burst_sram_bench.sv
module sync_burst_sram_bench;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 9;
  localparam int NV     = 8;

  localparam logic [ADDR_W-1:0] V_ADDR [NV] = '{9'd1, 9'd2, 9'd3, 9'd4, 9'd5, 9'd6, 9'd7, 9'd8};
  localparam logic [35:0] V_DATA [NV] = '{36'hF_EDCB_A987, 36'h1_2345_6789, 36'hA_AAAA_AAAA,
    36'h5_5555_5555, 36'hC_0FFE_E123, 36'h3_3333_3333, 36'h7_7777_7777, 36'h9_8765_4321};
  localparam logic V_GW  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic V_BWE [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic [3:0] V_BWN [NV] = '{4'hF, 4'hA, 4'hE, 4'h5, 4'h7, 4'h0, 4'hF, 4'h0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [35:0] wdata = '0;
  logic strobe_cpu_n = 1'b1, strobe_ctl_n = 1'b1, burst_step_n = 1'b1;
  logic wr_all_n = 1'b1, lane_wr_en_n = 1'b1;
  logic [3:0] lane_sel_n = 4'hF;
  logic cs1_n = 1'b0, cs2 = 1'b1, cs3_n = 1'b0;
  logic out_en_n = 1'b0, interleave = 1'b0, sleep = 1'b0;
  logic [35:0] rdata;
  logic rvalid;

  int total = 0;
  int bad = 0;
  logic [35:0] shadow [64];

  always #(CLK_P/2) clk = ~clk;

  sync_burst_sram #(.ADDR_W(ADDR_W)) u_sync_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
    .burst_step_n(burst_step_n), .wr_all_n(wr_all_n),
    .lane_wr_en_n(lane_wr_en_n), .lane_sel_n(lane_sel_n),
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .out_en_n(out_en_n),
    .interleave(interleave), .sleep(sleep), .rdata(rdata), .rvalid(rvalid)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [35:0] d,
                    input logic gw, input logic bwe, input logic [3:0] bwn);
    logic [3:0] m;
    strobe_ctl_n = 1'b0; addr = a; wdata = d;
    wr_all_n = gw; lane_wr_en_n = bwe; lane_sel_n = bwn;
    tick();
    strobe_ctl_n = 1'b1; wr_all_n = 1'b1; lane_wr_en_n = 1'b1; lane_sel_n = 4'hF;
    m = !gw ? 4'hF : (!bwe ? ~bwn : 4'h0);
    for (int i = 0; i < 4; i++)
      if (m[i]) shadow[a][i*9 +: 9] = d[i*9 +: 9];
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [35:0] d, output logic v);
    strobe_ctl_n = 1'b0; addr = a;
    tick();
    strobe_ctl_n = 1'b1;
    tick();
    d = rdata; v = rvalid;
  endtask

  task automatic burst(input logic [ADDR_W-1:0] b, input logic il, input logic use_cpu, input string req);
    logic [ADDR_W-1:0] ea;
    interleave = il;
    if (use_cpu) strobe_cpu_n = 1'b0; else strobe_ctl_n = 1'b0;
    addr = b;
    tick();
    strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; burst_step_n = 1'b0;
    for (int n = 0; n < 4; n++) begin
      if (n == 3) burst_step_n = 1'b1;
      tick();
      ea = b;
      ea[1:0] = il ? (b[1:0] ^ 2'(n)) : (b[1:0] + 2'(n));
      chk(req, rdata, shadow[ea]);
    end
    tick();
    chk("R9 suspend repeats address", rdata, shadow[ea]);
  endtask

  initial begin
    #(CLK_P * 50000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [35:0] d;
    logic v;
    tick(); tick(); tick();
    chk("R12 rvalid low in reset", {35'd0, rvalid}, 36'd0);
    rst_n = 1'b1;
    tick(); tick();
    chk("R12 rvalid low after reset", {35'd0, rvalid}, 36'd0);

    for (int a = 0; a < 16; a++) begin
      wr(ADDR_W'(a), 36'h1_0204_0810 * 36'(a + 1) ^ 36'h9_5A5A_A5A5, 1'b0, 1'b1, 4'hF);
    end
    for (int a = 0; a < 16; a++) begin
      rd(ADDR_W'(a), d, v);
      chk("R2 prefill readback", d, shadow[a]);
    end

    for (int i = 0; i < NV; i++) begin
      wr(V_ADDR[i], V_DATA[i], V_GW[i], V_BWE[i], V_BWN[i]);
      rd(V_ADDR[i], d, v);
      chk(i < 2 ? "R2 global write" : (i == 5 || i == 6) ? "R4 no lane write" : "R3 lane write",
          d, shadow[V_ADDR[i]]);
    end

    // R13 write then read on the very next cycle
    wr(9'd10, 36'hB_EEF0_0D11, 1'b0, 1'b1, 4'hF);
    rd(9'd10, d, v);
    chk("R13 read after write", d, 36'hB_EEF0_0D11);

    // R5 deselect with each chip-select wrong, write must be dropped
    for (int k = 0; k < 3; k++) begin
      cs1_n = (k == 0); cs2 = (k != 1); cs3_n = (k == 2);
      strobe_ctl_n = 1'b0; addr = 9'd5; wdata = 36'hD_DDDD_DDDD; wr_all_n = 1'b0;
      tick();
      strobe_ctl_n = 1'b1; wr_all_n = 1'b1; cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0;
      tick();
      chk("R5 deselect rvalid low", {35'd0, rvalid}, 36'd0);
      tick();
      chk("R5 no access after deselect", {35'd0, rvalid}, 36'd0);
    end
    rd(9'd5, d, v);
    chk("R5 deselected write dropped", d, shadow[5]);

    // R1 latency from an idle pipe
    strobe_ctl_n = 1'b0; cs2 = 1'b0;
    tick();
    strobe_ctl_n = 1'b1; cs2 = 1'b1;
    tick();
    strobe_ctl_n = 1'b0; addr = 9'd2;
    tick();
    strobe_ctl_n = 1'b1;
    chk("R1 not valid after one edge", {35'd0, rvalid}, 36'd0);
    tick();
    chk("R1 valid after two edges", {35'd0, rvalid}, 36'd1);
    chk("R1 data after two edges", rdata, shadow[2]);

    // R10 output enable is combinational
    out_en_n = 1'b1; #1;
    chk("R10 rvalid off", {35'd0, rvalid}, 36'd0);
    chk("R10 rdata zero", rdata, 36'd0);
    out_en_n = 1'b0; #1;
    chk("R10 rvalid back on", {35'd0, rvalid}, 36'd1);

    // R6 cpu strobe with cs1_n high is ignored
    rd(9'd3, d, v);
    strobe_cpu_n = 1'b0; cs1_n = 1'b1; addr = 9'd9;
    tick();
    strobe_cpu_n = 1'b1; cs1_n = 1'b0;
    tick();
    chk("R6 ignored strobe keeps burst", rdata, shadow[3]);
    chk("R6 still valid", {35'd0, rvalid}, 36'd1);

    // R7 / R8 / R9 bursts
    burst(9'd9, 1'b0, 1'b0, "R7 linear burst");
    burst(9'd9, 1'b1, 1'b1, "R8 interleaved burst");
    burst(9'd6, 1'b0, 1'b1, "R7 linear burst wrap");
    interleave = 1'b0;

    // R11 sleep
    sleep = 1'b1; #1;
    chk("R11 rvalid off in sleep", {35'd0, rvalid}, 36'd0);
    strobe_ctl_n = 1'b0; addr = 9'd4; wdata = 36'hE_EEEE_EEEE; wr_all_n = 1'b0;
    tick();
    strobe_ctl_n = 1'b1; wr_all_n = 1'b1;
    tick();
    chk("R11 rvalid low while asleep", {35'd0, rvalid}, 36'd0);
    sleep = 1'b0;
    tick(); tick();
    chk("R11 burst ended by sleep", {35'd0, rvalid}, 36'd0);
    rd(9'd4, d, v);
    chk("R11 contents kept", d, shadow[4]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule